// File: doc/BRIEF.md
# Transmit Empty Interrupt Delay Logic

This block produces the transmit-holding-empty interrupt and the transmitter-empty status bit for a UART transmitter that runs with its transmit FIFO enabled. When the FIFO has held two or more bytes at the same moment since it last drained, both indications come out as soon as their condition is met. When the FIFO only ever held one byte at a time, both are held back by roughly one character time. This keeps a host that feeds one byte at a time from being interrupted on every byte. The empty status bit itself is never delayed.

The block sits beside the transmit FIFO and the shift register. It watches the FIFO occupancy, the host's writes to the holding register, the host's reads of the interrupt identification register, writes to the FIFO control register, the shifter busy flag and a pulse marking the end of the final stop bit. All delays count the 16x baud enable, so they scale with the line rate. One character lasts `CHAR_BITS * OSR` ticks. The interrupt delay leaves out one stop bit and lasts `(CHAR_BITS-1) * OSR` ticks.

The interrupt machine has three states. `TH_IDLE` goes to `TH_PEND` when the FIFO drains after holding several bytes, or when an immediate request is armed while the FIFO is empty. It goes to `TH_DELAY` when the FIFO drains after holding only one byte. `TH_DELAY` goes to `TH_PEND` when the timer expires, and back to `TH_IDLE` on a holding-register write. `TH_PEND` goes to `TH_IDLE` on a holding-register write or an identification read. The empty-status machine also has three states. `TM_DONE` (TEMT high) goes to `TM_BUSY` when the FIFO or the shifter holds data. `TM_BUSY` goes to `TM_DONE` or `TM_WAIT` on the stop-done pulse with the FIFO empty. `TM_WAIT` goes to `TM_DONE` when the timer expires, and back to `TM_BUSY` if new data arrives. Both machines drop to their idle behaviour when the logic is disabled.

Top module: `txe_delay_ctrl`

## Requirements
- R1: `thre` is 1 exactly when `tx_count` is 0, in the same cycle, with no delay.
- R2: If the FIFO held at most one byte since it last emptied, `irq` rises (CHAR_BITS-1)*OSR baud ticks after the cycle in which `tx_count` reaches 0. With `baud_tick` high every cycle, that is (CHAR_BITS-1)*OSR+1 clock edges after `tx_count` is driven to 0.
- R3: If `tx_count` was 2 or more at any point since the FIFO last emptied, `irq` rises on the first clock edge after `tx_count` reaches 0.
- R4: A pulse on `fifo_wr` while the interrupt is pending clears `irq` on the next edge.
- R5: A pulse on `iir_rd` while the interrupt is pending clears `irq` on the next edge. The interrupt does not return while the FIFO stays empty.
- R6: `iid` is 4'h2 while the interrupt is pending and 4'h1 otherwise.
- R7: After a `fcr_wr` pulse, the next interrupt is raised with no delay: one edge after the FIFO empties, or on the second edge after the pulse if the FIFO is already empty. Later interrupts are delayed again.
- R8: With `fifo_en` or `thre_ie` low, `irq` stays 0, `iid` stays 4'h1, and TEMT sets on the first edge after `stop_done` with no delay.
- R9: A holding-register write during the delay cancels it. The next drain of the FIFO starts a full new delay.
- R10: The delay timers advance only on cycles with `baud_tick` high.
- R11: If the FIFO held at most one byte since TEMT was last 1, `temt` rises CHAR_BITS*OSR baud ticks after the `stop_done` cycle (CHAR_BITS*OSR+1 edges when ticking every cycle).
- R12: If `tx_count` reached 2 or more since TEMT was last 1, `temt` rises on the first edge after `stop_done`. `temt` falls one edge after `tx_count` becomes nonzero or `shifter_busy` goes high.
- R13: While the shifter is busy, `temt` stays 0 until `stop_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x baud enable, one cycle wide |
| tx_count | input | CNT_W | Current transmit FIFO occupancy |
| fifo_wr | input | 1 | Host write to the transmit holding register |
| iir_rd | input | 1 | Host read of the interrupt identification register |
| fcr_wr | input | 1 | Host write to the FIFO control register |
| fifo_en | input | 1 | FIFO mode enable |
| thre_ie | input | 1 | Transmit empty interrupt enable |
| shifter_busy | input | 1 | Transmit shift register holds a character |
| stop_done | input | 1 | Final stop bit fully shifted out |
| irq | output | 1 | Transmit empty interrupt request |
| iid | output | 4 | Interrupt identification code |
| thre | output | 1 | FIFO empty status |
| temt | output | 1 | Transmitter fully empty status |

## Verification
The bench fills the FIFO to every peak level from one byte up to the depth, then drains it. For each peak it checks that the interrupt and TEMT latencies switch from the full delay to immediate at exactly two bytes. A flag that cleared too early or set on one byte would show up as the wrong latency. It writes a byte in the middle of a delay, to catch a timer that resumes instead of restarting. It holds `baud_tick` low, to catch a timer that counts clock cycles. It exercises the one-shot immediate request after a FIFO-control write, including that the delay returns for the next interrupt. It also checks that an identification read does not let the interrupt come back while the FIFO is still empty.

// File: rtl/txe_pkg.sv
package txe_pkg;
    typedef enum logic [1:0] {
        TH_IDLE  = 2'd0,
        TH_DELAY = 2'd1,
        TH_PEND  = 2'd2
    } thre_st_t;

    typedef enum logic [1:0] {
        TM_DONE = 2'd0,
        TM_BUSY = 2'd1,
        TM_WAIT = 2'd2
    } temt_st_t;

    localparam logic [3:0] IID_NONE = 4'h1;
    localparam logic [3:0] IID_THRE = 4'h2;
endpackage

// File: rtl/txe_tick_timer.sv
module txe_tick_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;

    logic [W-1:0] cnt;

    assign done = run && tick && (cnt == W'(LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick)
            cnt <= done ? '0 : cnt + W'(1);
    end

    // R10: the count stays inside the programmed window
    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(LEN - 1));

    // R10: without a baud tick the count holds
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)) || !$past(run));
endmodule

// File: rtl/txe_thre_fsm.sv
module txe_thre_fsm
    import txe_pkg::*;
#(
    parameter int DLY = 144
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       baud_tick,
    input  logic       empty,
    input  logic       many,
    input  logic       fifo_wr,
    input  logic       iir_rd,
    input  logic       fcr_wr,
    output logic       irq,
    output logic [3:0] iid
);
    thre_st_t st, st_n;
    logic     prev_nz;
    logic     imm;
    logic     multi;
    logic     empty_evt;
    logic     t_done;

    assign empty_evt = prev_nz && empty;

    txe_tick_timer #(.LEN(DLY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st == TH_DELAY),
        .tick (baud_tick),
        .done (t_done)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            TH_IDLE:
                if (empty && (empty_evt || imm))
                    st_n = (multi || imm) ? TH_PEND : TH_DELAY;
            TH_DELAY:
                if (fifo_wr || !empty) st_n = TH_IDLE;
                else if (t_done)       st_n = TH_PEND;
            TH_PEND:
                if (fifo_wr || iir_rd) st_n = TH_IDLE;
            default: st_n = TH_IDLE;
        endcase
        if (!active) st_n = TH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= TH_IDLE;
            prev_nz <= 1'b0;
            imm     <= 1'b0;
            multi   <= 1'b0;
        end else begin
            st      <= st_n;
            prev_nz <= !empty;
            if (fcr_wr)
                imm <= 1'b1;
            else if (st_n == TH_PEND && st != TH_PEND)
                imm <= 1'b0;
            if (many)
                multi <= 1'b1;
            else if (empty)
                multi <= 1'b0;
        end
    end

    always_comb begin
        irq = (st == TH_PEND);
        iid = (st == TH_PEND) ? IID_THRE : IID_NONE;
    end

    p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TH_PEND && fifo_wr) |=> (st != TH_PEND));

    p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TH_PEND && iir_rd) |=> (st != TH_PEND));

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st == TH_IDLE));

    p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TH_DELAY && !baud_tick) |=> (st != TH_PEND));

    p_multi_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TH_IDLE && active && empty_evt && multi) |=> (st == TH_PEND));
endmodule

// File: rtl/txe_temt_fsm.sv
module txe_temt_fsm
    import txe_pkg::*;
#(
    parameter int DLY = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic baud_tick,
    input  logic empty,
    input  logic many,
    input  logic shifter_busy,
    input  logic stop_done,
    output logic temt
);
    temt_st_t st, st_n;
    logic     multi_t;
    logic     t_done;

    txe_tick_timer #(.LEN(DLY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st == TM_WAIT),
        .tick (baud_tick),
        .done (t_done)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            TM_DONE:
                if (!empty || shifter_busy) st_n = TM_BUSY;
            TM_BUSY:
                if (stop_done && empty)
                    st_n = (multi_t || !active) ? TM_DONE : TM_WAIT;
            TM_WAIT:
                if (!empty || shifter_busy) st_n = TM_BUSY;
                else if (!active || t_done) st_n = TM_DONE;
            default: st_n = TM_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= TM_DONE;
            multi_t <= 1'b0;
        end else begin
            st <= st_n;
            if (many)
                multi_t <= 1'b1;
            else if (st == TM_DONE)
                multi_t <= 1'b0;
        end
    end

    always_comb temt = (st == TM_DONE);

    p_no_early_temt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TM_BUSY && !stop_done) |=> (st != TM_DONE));

    p_wait_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TM_WAIT && !baud_tick && active) |=> (st != TM_DONE));
endmodule

// File: rtl/txe_delay_ctrl.sv
module txe_delay_ctrl
    import txe_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CHAR_BITS = 10,
    parameter int OSR       = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             fifo_wr,
    input  logic             iir_rd,
    input  logic             fcr_wr,
    input  logic             fifo_en,
    input  logic             thre_ie,
    input  logic             shifter_busy,
    input  logic             stop_done,
    output logic             irq,
    output logic [3:0]       iid,
    output logic             thre,
    output logic             temt
);
    localparam int THRE_DLY = (CHAR_BITS - 1) * OSR;
    localparam int TEMT_DLY = CHAR_BITS * OSR;

    logic empty;
    logic many;
    logic active;

    assign empty  = (tx_count == '0);
    assign many   = (tx_count > CNT_W'(1));
    assign active = fifo_en && thre_ie;
    assign thre   = empty;

    txe_thre_fsm #(.DLY(THRE_DLY)) u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .baud_tick(baud_tick),
        .empty    (empty),
        .many     (many),
        .fifo_wr  (fifo_wr),
        .iir_rd   (iir_rd),
        .fcr_wr   (fcr_wr),
        .irq      (irq),
        .iid      (iid)
    );

    txe_temt_fsm #(.DLY(TEMT_DLY)) u_temt (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .baud_tick   (baud_tick),
        .empty       (empty),
        .many        (many),
        .shifter_busy(shifter_busy),
        .stop_done   (stop_done),
        .temt        (temt)
    );

    p_fill_clears_temt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty || shifter_busy) |=> !temt);

    p_iid_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (iid == IID_NONE));
endmodule

// File: tb/txe_delay_ctrl_tb.sv
module txe_delay_ctrl_tb;
    localparam int DEPTH     = 4;
    localparam int CHAR_BITS = 3;
    localparam int OSR       = 2;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int THRE_DLY  = (CHAR_BITS - 1) * OSR;
    localparam int TEMT_DLY  = CHAR_BITS * OSR;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             baud_tick = 1'b1;
    logic [CNT_W-1:0] tx_count = '0;
    logic             fifo_wr = 1'b0;
    logic             iir_rd = 1'b0;
    logic             fcr_wr = 1'b0;
    logic             fifo_en = 1'b1;
    logic             thre_ie = 1'b1;
    logic             shifter_busy = 1'b0;
    logic             stop_done = 1'b0;
    logic             irq;
    logic [3:0]       iid;
    logic             thre;
    logic             temt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    txe_delay_ctrl #(.DEPTH(DEPTH), .CHAR_BITS(CHAR_BITS), .OSR(OSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_count(tx_count),
        .fifo_wr(fifo_wr), .iir_rd(iir_rd), .fcr_wr(fcr_wr), .fifo_en(fifo_en),
        .thre_ie(thre_ie), .shifter_busy(shifter_busy), .stop_done(stop_done),
        .irq(irq), .iid(iid), .thre(thre), .temt(temt)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int max, output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!irq && lat < max);
    endtask

    task automatic wait_temt(input int max, output int lat);
        stop_done    = 1'b1;
        shifter_busy = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            stop_done = 1'b0;
        end while (!temt && lat < max);
    endtask

    task automatic push(input int c);
        tx_count = CNT_W'(c);
        fifo_wr  = 1'b1;
        cyc(1);
        fifo_wr  = 1'b0;
    endtask

    task automatic clear_irq();
        iir_rd = 1'b1;
        cyc(1);
        iir_rd = 1'b0;
    endtask

    task automatic settle();
        tx_count = '0;
        shifter_busy = 1'b0;
        stop_done = 1'b1;
        cyc(1);
        stop_done = 1'b0;
        cyc(TEMT_DLY + 4);
        clear_irq();
        cyc(1);
    endtask

    initial begin
        int lat;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // reset state
        check("R6 reset irq", int'(irq), 0);
        check("R6 reset iid", int'(iid), 1);
        check("R1 reset thre", int'(thre), 1);
        check("R11 reset temt", int'(temt), 1);

        // R1: THRE tracks occupancy with no delay
        for (int c = 0; c <= DEPTH; c++) begin
            tx_count = CNT_W'(c);
            #1;
            check("R1 thre vs count", int'(thre), (c == 0) ? 1 : 0);
            cyc(1);
        end
        settle();

        // R2, R6, R5: single byte then iir read
        push(1);
        cyc(2);
        check("R2 no irq while nonempty", int'(irq), 0);
        tx_count = '0;
        wait_irq(30, lat);
        check("R2 single byte latency", lat, THRE_DLY + 1);
        check("R6 iid pending", int'(iid), 2);
        clear_irq();
        check("R5 iir read clears", int'(irq), 0);
        check("R6 iid idle", int'(iid), 1);
        cyc(10);
        check("R5 no return while empty", int'(irq), 0);

        // R2/R3/R11/R12/R13 sweep over peak occupancy
        for (int p = 1; p <= DEPTH; p++) begin
            settle();
            shifter_busy = 1'b1;
            for (int k = 1; k <= p; k++) push(k);
            for (int k = p - 1; k >= 1; k--) begin
                tx_count = CNT_W'(k);
                cyc(1);
            end
            tx_count = '0;
            wait_irq(30, lat);
            check((p >= 2) ? "R3 multi-byte latency" : "R2 one-byte latency",
                  lat, (p >= 2) ? 1 : THRE_DLY + 1);
            cyc(TEMT_DLY + 2);
            check("R13 temt held before stop", int'(temt), 0);
            wait_temt(30, lat);
            check((p >= 2) ? "R12 temt multi latency" : "R11 temt one-byte latency",
                  lat, (p >= 2) ? 1 : TEMT_DLY + 1);
        end

        // R4: holding write clears pending interrupt
        check("R4 pending before write", int'(irq), 1);
        push(1);
        check("R4 write clears", int'(irq), 0);
        settle();

        // R9: write during delay restarts it
        push(1);
        tx_count = '0;
        cyc(3);
        check("R9 still delaying", int'(irq), 0);
        push(1);
        tx_count = '0;
        wait_irq(30, lat);
        check("R9 full delay after restart", lat, THRE_DLY + 1);
        settle();

        // R10: only baud ticks advance the delay
        push(1);
        baud_tick = 1'b0;
        tx_count = '0;
        cyc(20);
        check("R10 stalled without ticks", int'(irq), 0);
        baud_tick = 1'b1;
        wait_irq(30, lat);
        check("R10 remaining ticks", lat, THRE_DLY);
        settle();

        // R7: immediate after FIFO-control write
        fcr_wr = 1'b1;
        cyc(1);
        fcr_wr = 1'b0;
        check("R7 one edge after fcr", int'(irq), 0);
        cyc(1);
        check("R7 immediate while empty", int'(irq), 1);
        clear_irq();
        cyc(5);
        check("R7 one shot", int'(irq), 0);
        fcr_wr = 1'b1;
        push(1);
        fcr_wr = 1'b0;
        tx_count = '0;
        wait_irq(30, lat);
        check("R7 immediate on drain", lat, 1);
        clear_irq();
        push(1);
        tx_count = '0;
        wait_irq(30, lat);
        check("R7 delay returns after first", lat, THRE_DLY + 1);
        settle();

        // R8: disabled
        thre_ie = 1'b0;
        push(1);
        tx_count = '0;
        cyc(15);
        check("R8 no irq when disabled", int'(irq), 0);
        check("R8 iid when disabled", int'(iid), 1);
        wait_temt(30, lat);
        check("R8 temt undelayed", lat, 1);
        thre_ie = 1'b1;
        cyc(3);
        check("R8 no spurious on enable", int'(irq), 0);
        fifo_en = 1'b0;
        push(1);
        tx_count = '0;
        cyc(15);
        check("R8 no irq fifo off", int'(irq), 0);
        fifo_en = 1'b1;
        settle();

        // R12: temt falls on fill or shifter busy
        tx_count = CNT_W'(1);
        cyc(1);
        check("R12 temt falls on fill", int'(temt), 0);
        settle();
        shifter_busy = 1'b1;
        cyc(1);
        check("R12 temt falls on busy", int'(temt), 0);
        cyc(4);
        check("R13 no temt without stop", int'(temt), 0);
        wait_temt(30, lat);
        check("R11 temt delay, no fill", lat, TEMT_DLY + 1);

        summary();
        $finish;
    end
endmodule